// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block is the sequencing core of a microprogrammed control unit. A microprogram counter addresses a small read-only control store. The microinstruction at that address drives its control-signal field onto a registered output bus. In the same cycle, next-address logic decides where the counter goes next. Each microinstruction carries one explicit target address, a two-bit sequencing code and a condition-select field. Together with a bank of condition flags and the opcode of the current machine instruction, these fields pick one of three sources: the counter plus one, the target address, or a slot address formed from the opcode.

The control store contents are a single packed parameter. An integrating design supplies its own microprogram through that parameter. After reset the counter sits at address 0, where the instruction-fetch routine is expected to start. The sequencing code works as the machine's transition selector, a two-bit enumeration decoded with a unique case:

- `SEQ_NEXT` (00) is the step transition.
- `SEQ_COND` (01) is the test transition.
- `SEQ_JUMP` (10) is the goto transition.
- `SEQ_MAP` (11) is the dispatch transition.

The counter value is the machine's state. Reset is the only other transition, and it forces state 0.

Top module: `useq_top`

## Requirements
- R1: An active-low asynchronous reset forces `uaddr` to 0 and `ctrl_out` to all zeros at once, independent of the clock.
- R2: With sequencing code 00 in the current word, the next `uaddr` is the current `uaddr` plus one.
- R3: With sequencing code 10, the next `uaddr` is the word's target field.
- R4: With sequencing code 11, the next `uaddr` is `opcode` shifted left by (address width minus opcode width). `opcode` has no effect under any other code.
- R5: With sequencing code 01 and the selected flag at 1, the next `uaddr` is the target field.
- R6: With sequencing code 01 and the selected flag at 0, the next `uaddr` is the current `uaddr` plus one.
- R7: The condition-select field is a bit index into `cond_in`. Only that bit decides a code-01 branch.
- R8: Incrementing from the last store address wraps to address 0.
- R9: The stored word is laid out from the top bit down as four fields: the control field (CTRL_W bits), the sequencing code (2 bits), the condition select (CS_W bits) and the target (AW bits). `ctrl_out` shows the control field of the word at the current `uaddr` one clock edge after that address is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | OPC_W | Opcode of the current machine instruction, used for dispatch |
| cond_in | input | 2**CS_W | Condition flags from the datapath |
| uaddr | output | AW | Microprogram counter (address being fetched) |
| ctrl_out | output | CTRL_W | Registered control signals |

## Verification
Every cycle, the checker compares the counter's next value against the source that the current sequencing code names (step, goto, test taken or not taken, dispatch). It also confirms that the control bus follows the fetched word with one edge of delay. Other behaviours can only be shown by the bench's scenarios, because each needs a complete microprogram run:

- the asynchronous action of reset;
- the wrap from the top address;
- the fact that an opcode change in mid-routine leaves the flow untouched;
- the choice of flag by bit index.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // Sequencing codes; the encoding is fixed by the microinstruction format
    typedef enum logic [1:0] {
        SEQ_NEXT = 2'b00,
        SEQ_COND = 2'b01,
        SEQ_JUMP = 2'b10,
        SEQ_MAP  = 2'b11
    } seq_e;

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int AW     = 6,
    parameter int WORD_W = 18,
    parameter logic [(2**AW)*WORD_W-1:0] INIT = '0
) (
    input  logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] word
);
    localparam int DEPTH = 2**AW;

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign mem[i] = INIT[i*WORD_W +: WORD_W];
    end

    assign word = mem[addr];

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW    = 6,
    parameter int CS_W  = 2,
    parameter int OPC_W = 3
) (
    input  logic [1:0]         seq,
    input  logic [CS_W-1:0]    csel,
    input  logic [AW-1:0]      tgt,
    input  logic [AW-1:0]      upc,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [2**CS_W-1:0] flags,
    output logic [AW-1:0]      nxt
);
    localparam int MAP_SHIFT = AW - OPC_W;

    seq_e          code;
    logic [AW-1:0] inc_addr;
    logic [AW-1:0] map_addr;
    logic          hit;

    assign code     = seq_e'(seq);
    assign inc_addr = upc + 1'b1;
    assign map_addr = AW'(opcode) << MAP_SHIFT;
    assign hit      = flags[csel];

    always_comb begin
        unique case (code)
            SEQ_NEXT: nxt = inc_addr;
            SEQ_COND: nxt = hit ? tgt : inc_addr;
            SEQ_JUMP: nxt = tgt;
            SEQ_MAP:  nxt = map_addr;
            default:  nxt = inc_addr;
        endcase
    end

endmodule

// File: rtl/useq_top.sv
module useq_top #(
    parameter int CTRL_W = 8,
    parameter int AW     = 6,
    parameter int CS_W   = 2,
    parameter int OPC_W  = 3,
    parameter logic [(2**AW)*(CTRL_W+2+CS_W+AW)-1:0] STORE_INIT = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OPC_W-1:0]     opcode,
    input  logic [2**CS_W-1:0]   cond_in,
    output logic [AW-1:0]        uaddr,
    output logic [CTRL_W-1:0]    ctrl_out
);
    localparam int WORD_W  = CTRL_W + 2 + CS_W + AW;
    localparam int TGT_LO  = 0;
    localparam int CSEL_LO = AW;
    localparam int SEQ_LO  = AW + CS_W;
    localparam int CTRL_LO = AW + CS_W + 2;

    logic [WORD_W-1:0] cur_word;
    logic [AW-1:0]     cur_tgt;
    logic [CS_W-1:0]   cur_csel;
    logic [1:0]        cur_seq;
    logic [CTRL_W-1:0] cur_ctrl;
    logic [AW-1:0]     nxt_addr;

    useq_store #(
        .AW     (AW),
        .WORD_W (WORD_W),
        .INIT   (STORE_INIT)
    ) u_store (
        .addr (uaddr),
        .word (cur_word)
    );

    assign cur_tgt  = cur_word[TGT_LO  +: AW];
    assign cur_csel = cur_word[CSEL_LO +: CS_W];
    assign cur_seq  = cur_word[SEQ_LO  +: 2];
    assign cur_ctrl = cur_word[CTRL_LO +: CTRL_W];

    useq_next #(
        .AW    (AW),
        .CS_W  (CS_W),
        .OPC_W (OPC_W)
    ) u_next (
        .seq    (cur_seq),
        .csel   (cur_csel),
        .tgt    (cur_tgt),
        .upc    (uaddr),
        .opcode (opcode),
        .flags  (cond_in),
        .nxt    (nxt_addr)
    );

    // State register: the microprogram counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uaddr <= '0;
        end else begin
            uaddr <= nxt_addr;
        end
    end

    // Output register: control signals of the fetched word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_out <= '0;
        end else begin
            ctrl_out <= cur_ctrl;
        end
    end

endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
#(
    parameter int CTRL_W = 8,
    parameter int AW     = 6,
    parameter int CS_W   = 2,
    parameter int OPC_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [AW-1:0]      uaddr,
    input logic [CTRL_W-1:0]  ctrl_out,
    input logic [1:0]         seq,
    input logic [CS_W-1:0]    csel,
    input logic [AW-1:0]      tgt,
    input logic [CTRL_W-1:0]  ctrl_fld,
    input logic [OPC_W-1:0]   opcode,
    input logic [2**CS_W-1:0] cond_in
);
    localparam int SHIFT = AW - OPC_W;

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq == SEQ_NEXT) |=> (uaddr == AW'($past(uaddr) + 1'b1)));

    // R3
    goto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq == SEQ_JUMP) |=> (uaddr == $past(tgt)));

    // R4
    dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq == SEQ_MAP) |=> (uaddr == (AW'($past(opcode)) << SHIFT)));

    // R5
    test_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq == SEQ_COND && cond_in[csel]) |=> (uaddr == $past(tgt)));

    // R6
    test_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq == SEQ_COND && !cond_in[csel]) |=> (uaddr == AW'($past(uaddr) + 1'b1)));

    // R9
    ctrl_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctrl_out == $past(ctrl_fld)));

endmodule

bind useq_top useq_chk #(
    .CTRL_W (CTRL_W),
    .AW     (AW),
    .CS_W   (CS_W),
    .OPC_W  (OPC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .uaddr    (uaddr),
    .ctrl_out (ctrl_out),
    .seq      (cur_seq),
    .csel     (cur_csel),
    .tgt      (cur_tgt),
    .ctrl_fld (cur_ctrl),
    .opcode   (opcode),
    .cond_in  (cond_in)
);

// File: tb/useq_top_bench.sv
module useq_top_bench;

    localparam int CTRL_W = 8;
    localparam int AW     = 6;
    localparam int CS_W   = 2;
    localparam int OPC_W  = 3;
    localparam int WW     = CTRL_W + 2 + CS_W + AW;
    localparam int DEPTH  = 2**AW;

    // Entry: ctrl = 0x80 | address, so ctrl_out names the fetched address
    function automatic logic [WW-1:0] ent(int a, logic [1:0] sq, int cs, int t);
        logic [7:0] c;
        c = 8'h80 | 8'(a);
        return {c, sq, CS_W'(cs), AW'(t)};
    endfunction

    function automatic logic [DEPTH*WW-1:0] prog();
        logic [DEPTH*WW-1:0] p;
        for (int i = 0; i < DEPTH; i++) p[i*WW +: WW] = ent(i, 2'b10, 0, 0);
        p[0*WW  +: WW] = ent(0,  2'b00, 0, 0);
        p[1*WW  +: WW] = ent(1,  2'b11, 0, 0);
        p[8*WW  +: WW] = ent(8,  2'b00, 0, 0);
        p[9*WW  +: WW] = ent(9,  2'b00, 0, 0);
        p[10*WW +: WW] = ent(10, 2'b10, 0, 0);
        p[16*WW +: WW] = ent(16, 2'b01, 1, 20);
        p[24*WW +: WW] = ent(24, 2'b01, 3, 30);
        p[56*WW +: WW] = ent(56, 2'b10, 0, 63);
        p[63*WW +: WW] = ent(63, 2'b00, 0, 0);
        return p;
    endfunction

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [OPC_W-1:0]  opcode = '0;
    logic [3:0]        cond_in = '0;
    logic [AW-1:0]     uaddr;
    logic [CTRL_W-1:0] ctrl_out;
    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    useq_top #(
        .CTRL_W (CTRL_W), .AW (AW), .CS_W (CS_W), .OPC_W (OPC_W),
        .STORE_INIT (prog())
    ) u_useq_top (
        .clk (clk), .rst_n (rst_n), .opcode (opcode), .cond_in (cond_in),
        .uaddr (uaddr), .ctrl_out (ctrl_out)
    );

    task automatic check(string req, int exp_a, int exp_c);
        total++;
        if (uaddr !== AW'(exp_a) || ctrl_out !== CTRL_W'(exp_c)) begin
            bad++;
            $display("FAIL %s: uaddr=%0d ctrl=%h expected uaddr=%0d ctrl=%h",
                     req, uaddr, ctrl_out, exp_a, exp_c);
        end
    endtask

    task automatic step(string req, int exp_a, int prev_a);
        @(posedge clk);
        @(negedge clk);
        check(req, exp_a, 8'h80 | prev_a);
    endtask

    task automatic start(logic [OPC_W-1:0] op, logic [3:0] fl);
        rst_n = 1'b0;
        opcode = op;
        cond_in = fl;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", 0, 0);
        step("R2", 1, 0);
    endtask

    task automatic t_sequential();
        start(3'd1, 4'b0000);
        step("R4", 8, 1);
        step("R2", 9, 8);
        step("R2", 10, 9);
        step("R3", 0, 10);
        step("R2", 1, 0);
    endtask

    task automatic t_taken();
        start(3'd2, 4'b0010);
        step("R4", 16, 1);
        step("R5", 20, 16);
        step("R3", 0, 20);
    endtask

    task automatic t_fallthrough();
        start(3'd2, 4'b1101);
        step("R4", 16, 1);
        step("R6", 17, 16);
        step("R3", 0, 17);
    endtask

    task automatic t_select();
        start(3'd3, 4'b1000);
        step("R4", 24, 1);
        step("R7", 30, 24);
        start(3'd3, 4'b0111);
        step("R4", 24, 1);
        step("R7", 25, 24);
        step("R3", 0, 25);
    endtask

    task automatic t_wrap();
        start(3'd7, 4'b0000);
        step("R4", 56, 1);
        step("R3", 63, 56);
        step("R8", 0, 63);
    endtask

    task automatic t_opcode_ignored();
        start(3'd1, 4'b0000);
        step("R4", 8, 1);
        opcode = 3'd2;
        step("R4", 9, 8);
        step("R4", 10, 9);
        step("R4", 0, 10);
    endtask

    task automatic t_async_reset();
        start(3'd1, 4'b0000);
        step("R4", 8, 1);
        step("R2", 9, 8);
        #0.5 rst_n = 1'b0;
        #0.5 check("R1", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R9", 1, 0);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_sequential();
        t_taken();
        t_fallthrough();
        t_select();
        t_wrap();
        t_opcode_ignored();
        t_async_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule